// File: doc/BRIEF.md
# Multi-Word Program Command Sequencer

This block is the bus-write command front end of a NOR-style flash. A host issues single-cycle writes. A setup code selects either a two-word or a four-word page program. The following writes each latch one address and one data word. The write that supplies the last word starts a modelled program controller. That controller waits a fixed number of cycles and then writes each latched word into a small on-chip array. Each write is a bit-wise AND of the old contents with the new data, because a program can only turn ones into zeros.

Before the controller starts, the sequencer checks two conditions. All latched addresses must fall in one aligned page, and the programming-supply flag must be good. If either check fails, the program does not run and a sticky error bit is raised instead. Error bits stay set until a clear command is written. From the setup write onward, reads return the status byte, until an array-read command is written in idle. A synchronous reset aborts any program in progress.

Top module: `mwp_seq_top`

## Requirements
- R1: After reset, `busy` is 0, reads return array words (erased words read 0xFFFF), and the first status read shows 0x0080 (ready set, every error bit clear).
- R2: In idle, data byte 0x30 arms a two-word program. The next two writes latch address/data pairs. If both addresses differ only in bit 0 and `vpp_ok` is 1 on the second of them, each target word becomes its old value AND the new data.
- R3: In idle, data byte 0x56 arms a four-word program. The next four writes latch pairs. If all four addresses differ only in bits 1 and 0 and `vpp_ok` is 1 on the last write, each word is ANDed in the order latched.
- R4: A started program holds `busy` high for exactly PROG_CYCLES plus the word count (2 or 4) clock cycles, counted from the edge that latched the last word. While `busy` is high, status bit 7 (ready) reads 0.
- R5: From a setup write onward, a read returns the status byte zero-extended on `rd_data`. The layout is bit 7 ready, bit 5 sequence error, bit 4 program error, bit 3 supply error; bits 6, 2, 1 and 0 read 0.
- R6: If any latched address leaves the page of the first one, no program starts, `busy` stays 0, the array is untouched and status bit 5 is set.
- R7: If `vpp_ok` is 0 on the last latch write, no program starts, the array is untouched and status bit 3 is set.
- R8: If a programmed word requests a 1 where the array already holds a 0, status bit 4 is set.
- R9: Error bits are sticky across later successful programs. Data byte 0x50 written in idle clears bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R10: Writes made while `busy` is high are ignored, including the array-read command.
- R11: Asserting `rst` during a program aborts it: `busy` is 0 on the next cycle and reads return array data.
- R12: Data byte 0xFF written in idle returns reads to array data. Any other unassigned byte written in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running program |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| addr | input | AW | Word address for writes and reads |
| wdata | input | DW | Write data; the low byte carries command codes |
| vpp_ok | input | 1 | Programming supply at program level |
| rd_data | output | DW | Registered read data: array word or zero-extended status |
| busy | output | 1 | Program controller running |

## Verification
A wrong sequencer state is visible at the ports within a few cycles. A missed latch or a wrong word index corrupts a page word, which appears on the next array read. A wrong mode flag makes the very next read return status instead of array data, or the reverse. Counter faults show up as a `busy` pulse whose length differs from PROG_CYCLES plus the word count. Sticky-bit faults appear on the status read that follows each sequence, so a lost or spuriously cleared error is caught before the next command.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  localparam logic [7:0] OP_PAIR  = 8'h30;
  localparam logic [7:0] OP_QUAD  = 8'h56;
  localparam logic [7:0] OP_CLR   = 8'h50;
  localparam logic [7:0] OP_ARRAY = 8'hFF;

  localparam int SR_READY = 7;
  localparam int SR_SEQ   = 5;
  localparam int SR_PGM   = 4;
  localparam int SR_VPP   = 3;
  localparam int SR_PROT  = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_GATHER, ST_COUNT, ST_WRITE} seq_st_e;
endpackage

// File: rtl/mwp_array.sv
module mwp_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] old_word,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // erased state of a flash cell is all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= mem[waddr] & wdata;
  end

  assign old_word = mem[waddr];
  assign rword    = mem[raddr];
endmodule

// File: rtl/mwp_ctrl.sv
module mwp_ctrl import mwp_pkg::*; #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          vpp_ok,
  input  logic [DW-1:0] old_word,
  output logic          busy,
  output logic          stat_mode,
  output logic [7:0]    sr,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data
);
  localparam int SLOTS = 4;
  localparam int IW    = $clog2(SLOTS);
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  seq_st_e       st;
  logic [AW-1:0] slot_a [SLOTS];
  logic [DW-1:0] slot_d [SLOTS];
  logic [IW-1:0] idx;
  logic [IW-1:0] last;
  logic          quad;
  logic [CW-1:0] cnt;
  logic          seq_bad;
  logic          err_seq, err_pgm, err_vpp;
  logic [AW-1:0] pmask;
  logic          page_ok;
  logic          bad_next;

  // page mask: drop bit 0 for a pair, bits 1..0 for a quad
  assign pmask    = quad ? {{(AW-2){1'b1}}, 2'b00} : {{(AW-1){1'b1}}, 1'b0};
  assign page_ok  = ((addr ^ slot_a[0]) & pmask) == '0;
  assign bad_next = seq_bad | ((idx != '0) & ~page_ok);

  assign arr_we   = (st == ST_WRITE);
  assign arr_addr = slot_a[idx];
  assign arr_data = slot_d[idx];
  assign sr       = {~busy, 1'b0, err_seq, err_pgm, err_vpp, 1'b0, 1'b0, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      stat_mode <= 1'b0;
      idx       <= '0;
      last      <= '0;
      quad      <= 1'b0;
      cnt       <= '0;
      seq_bad   <= 1'b0;
      err_seq   <= 1'b0;
      err_pgm   <= 1'b0;
      err_vpp   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (wr_en) begin
          case (wdata[7:0])
            OP_PAIR: begin
              st <= ST_GATHER; quad <= 1'b0; last <= IW'(1);
              idx <= '0; seq_bad <= 1'b0; stat_mode <= 1'b1;
            end
            OP_QUAD: begin
              st <= ST_GATHER; quad <= 1'b1; last <= IW'(3);
              idx <= '0; seq_bad <= 1'b0; stat_mode <= 1'b1;
            end
            OP_CLR: begin
              err_seq <= 1'b0; err_pgm <= 1'b0; err_vpp <= 1'b0;
            end
            OP_ARRAY: stat_mode <= 1'b0;
            default: ;
          endcase
        end
        ST_GATHER: if (wr_en) begin
          slot_a[idx] <= addr;
          slot_d[idx] <= wdata;
          if (idx == last) begin
            idx <= '0;
            if (bad_next || !vpp_ok) begin
              st <= ST_IDLE;
              if (bad_next) err_seq <= 1'b1;
              if (!vpp_ok)  err_vpp <= 1'b1;
            end else begin
              st   <= ST_COUNT;
              busy <= 1'b1;
              cnt  <= '0;
            end
          end else begin
            idx     <= idx + 1'b1;
            seq_bad <= bad_next;
          end
        end
        ST_COUNT: begin
          if (cnt == CW'(PROG_CYCLES - 1)) st <= ST_WRITE;
          else cnt <= cnt + 1'b1;
        end
        ST_WRITE: begin
          if ((old_word & arr_data) != arr_data) err_pgm <= 1'b1;
          if (idx == last) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            idx  <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwp_seq_top.sv
module mwp_seq_top #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          vpp_ok,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] old_word;
  logic [DW-1:0] rword;
  logic [7:0]    sr;
  logic          stat_mode;

  mwp_ctrl #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vpp_ok(vpp_ok), .old_word(old_word), .busy(busy), .stat_mode(stat_mode),
    .sr(sr), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  mwp_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wdata(arr_data),
    .raddr(addr), .old_word(old_word), .rword(rword)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= stat_mode ? {{(DW-8){1'b0}}, sr} : rword;
  end
endmodule

// File: rtl/mwp_seq_chk.sv
module mwp_seq_chk import mwp_pkg::*; (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] op,
  input logic       busy,
  input logic       arr_we,
  input logic [7:0] sr
);
  a_r4_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  a_r11_reset_idles: assert property (@(posedge clk)
    rst |=> (!busy && !arr_we));

  a_r6_no_start_on_seq_err: assert property (@(posedge clk) disable iff (rst)
    $rose(sr[SR_SEQ]) |-> !busy);

  a_r7_no_start_on_vpp_err: assert property (@(posedge clk) disable iff (rst)
    $rose(sr[SR_VPP]) |-> !busy);

  a_r4_busy_ends_after_write: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> $past(arr_we));

  a_r9_pgm_sticky: assert property (@(posedge clk) disable iff (rst)
    ($fell(sr[SR_PGM]) && !$past(rst)) |-> $past(wr_en && op == OP_CLR));

  a_r9_seq_sticky: assert property (@(posedge clk) disable iff (rst)
    ($fell(sr[SR_SEQ]) && !$past(rst)) |-> $past(wr_en && op == OP_CLR));

  a_r9_vpp_sticky: assert property (@(posedge clk) disable iff (rst)
    ($fell(sr[SR_VPP]) && !$past(rst)) |-> $past(wr_en && op == OP_CLR));
endmodule

bind mwp_seq_top mwp_seq_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .op(wdata[7:0]),
  .busy(busy), .arr_we(arr_we), .sr(sr)
);

// File: tb/tb_mwp_seq_top.sv
module tb_mwp_seq_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PROG_CYCLES = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, wr_en = 0, vpp_ok = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic busy;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [1 << AW];
  bit e_seq = 0, e_pgm = 0, e_vpp = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mwp_seq_top #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vpp_ok(vpp_ok), .rd_data(rd_data), .busy(busy)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_sr();
    return {8'h00, 1'b1, 1'b0, e_seq, e_pgm, e_vpp, 3'b000};
  endfunction

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic run_prog(bit q, logic [AW-1:0] a [4], logic [DW-1:0] d [4],
                          bit v, string tag, string peek);
    int n;
    logic [AW-1:0] m;
    bit bad;
    int bc;
    logic [DW-1:0] r;
    logic [DW-1:0] old;
    n = q ? 4 : 2;
    m = q ? 8'hFC : 8'hFE;
    bad = 0;
    bus_write('0, q ? 16'h0056 : 16'h0030);
    rd('0, r);
    check({peek, " status after setup"}, r, exp_sr());
    for (int i = 1; i < n; i++) if (((a[i] ^ a[0]) & m) != '0) bad = 1;
    vpp_ok = v;
    for (int i = 0; i < n; i++) bus_write(a[i], d[i]);
    if (bad || !v) begin
      check(bad ? "R6 no busy on page error" : "R7 no busy on low supply",
            {15'b0, busy}, 16'h0);
      if (bad) e_seq = 1;
      if (!v) e_vpp = 1;
    end else begin
      bc = int'(busy);
      rd(a[0], r);
      bc += int'(busy);
      check("R4 ready bit low while busy", {15'b0, r[7]}, 16'h0);
      bus_write(a[0], 16'h00FF);
      bc += int'(busy);
      while (busy && bc < 1000) begin
        @(negedge clk);
        bc += int'(busy);
      end
      check("R4 busy length", DW'(bc), DW'(PROG_CYCLES + n));
      for (int i = 0; i < n; i++) begin
        old = model[a[i]];
        if ((old & d[i]) != d[i]) e_pgm = 1;
        model[a[i]] = old & d[i];
      end
    end
    vpp_ok = 1;
    rd('0, r);
    check("R5 R10 status after sequence", r, exp_sr());
    bus_write('0, 16'h00FF);
    for (int i = 0; i < n; i++) begin
      rd(a[i], r);
      check({tag, " array word"}, r, model[a[i]]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] aa [4];
    logic [DW-1:0] dd [4];
    logic [DW-1:0] r;
    bit q;
    logic [AW-1:0] base;
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << AW); i++) model[i] = '1;
    repeat (4) @(negedge clk);
    rst = 0;
    check("R1 busy after reset", {15'b0, busy}, 16'h0);
    rd(8'h05, r);
    check("R1 array read after reset", r, 16'hFFFF);

    // R2 directed pair, first status read also covers R1
    aa = '{8'h10, 8'h11, 8'h00, 8'h00};
    dd = '{16'hA5A5, 16'h0F0F, 16'h0, 16'h0};
    run_prog(0, aa, dd, 1, "R2", "R1");

    // R3 directed quad, scrambled order
    aa = '{8'h22, 8'h20, 8'h23, 8'h21};
    dd = '{16'h1234, 16'hFF00, 16'h00FF, 16'h8001};
    run_prog(1, aa, dd, 1, "R3", "R5");

    // R8 request ones over programmed zeros
    aa = '{8'h11, 8'h10, 8'h00, 8'h00};
    dd = '{16'hFFFF, 16'h0F0F, 16'h0, 16'h0};
    run_prog(0, aa, dd, 1, "R8", "R5");

    // R9 error bit survives a clean program, then clear
    aa = '{8'h30, 8'h31, 8'h00, 8'h00};
    dd = '{16'h7777, 16'h3333, 16'h0, 16'h0};
    run_prog(0, aa, dd, 1, "R9", "R9");
    bus_write('0, 16'h0050);
    e_seq = 0; e_pgm = 0; e_vpp = 0;
    bus_write('0, 16'h0030);
    rd('0, r);
    check("R9 status cleared", r, exp_sr());
    bus_write(8'h34, 16'h0);
    bus_write(8'h35, 16'hFFFF);
    while (busy) @(negedge clk);
    model[8'h34] = 16'h0;
    bus_write('0, 16'h00FF);

    // R6 page violation on a pair
    aa = '{8'h38, 8'h3A, 8'h00, 8'h00};
    dd = '{16'h0000, 16'h0000, 16'h0, 16'h0};
    run_prog(0, aa, dd, 1, "R6", "R5");

    // R7 low supply on a quad
    aa = '{8'h40, 8'h41, 8'h42, 8'h43};
    dd = '{16'h0, 16'h0, 16'h0, 16'h0};
    run_prog(1, aa, dd, 0, "R7", "R5");

    // R12 unknown code in idle is ignored
    bus_write('0, 16'h0012);
    rd(8'h10, r);
    check("R12 unknown code keeps array read", r, model[8'h10]);

    // R11 reset during a program
    bus_write('0, 16'h0030);
    bus_write(8'h60, 16'h0);
    bus_write(8'h61, 16'h0);
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R11 busy dropped by reset", {15'b0, busy}, 16'h0);
    rd(8'h22, r);
    check("R11 array read after abort", r, model[8'h22]);
    e_seq = 0; e_pgm = 0; e_vpp = 0;

    // random sequences on the upper half
    for (int it = 0; it < 40; it++) begin
      q = bit'($urandom_range(0, 1));
      base = 8'h80 | AW'($urandom_range(0, 31) << 2);
      for (int i = 0; i < 4; i++) begin
        aa[i] = base | AW'(q ? $urandom_range(0, 3) : $urandom_range(0, 1));
        dd[i] = ($urandom_range(0, 7) == 0) ? 16'hFFFF : DW'($urandom & $urandom);
      end
      if ($urandom_range(0, 7) == 0) aa[q ? 3 : 1] = aa[q ? 3 : 1] ^ 8'h10;
      run_prog(q, aa, dd, $urandom_range(0, 9) != 0, q ? "R3" : "R2", "R5");
      if (it % 5 == 4) begin
        bus_write('0, 16'h0050);
        e_seq = 0; e_pgm = 0; e_vpp = 0;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule